// File: doc/BRIEF.md
# LCD Segment Blink Controller

This block decides, cycle by cycle, which of eight LCD segments are lit. The segments hang off two segment pins, with up to four commons each. Software writes a segment data byte and a per-segment blink mask. It also writes an 8-bit toggle-rate value and a drive-mode select, all through a small register bus. A divider runs from a slow timebase tick and inverts a shared blink phase. Segments whose mask bit is set are gated by that phase, so they flash on their own. The host can then sleep and, for example, let a clock colon blink once a second while it wakes only once a minute to update the digits.

The outputs are the effective segment-on bits, already qualified by the drive mode. In static drive only the common-0 segments of the two pins are live. In 4-mux drive all eight are live. Waveform generation, bias and charge pumping are left to downstream logic.

Top module: `lcd_blink_top`

## Requirements
- R1: After reset the mask, data, toggle-rate and mode registers read 0, all `segOn` bits are 0 and the blink phase is in the "on" state.
- R2: Registers are mapped as follows: mask at 0x80, segment data at 0x81, toggle rate at 0x82, and mode at 0x83 (bit 0 only; 1 = 4-mux, 0 = static). Each reads back its written value on `busRdData` combinationally from `busAddr`. Unused mode bits and any unmapped address read 0.
- R3: A segment whose mask bit is 0 shows its data bit steadily, in either blink phase.
- R4: A segment whose mask bit is 1 and data bit is 1 is lit during the "on" phase and dark during the "off" phase.
- R5: A segment whose data bit is 0 is dark whatever its mask bit and the phase.
- R6: On each `tick`, a tick counter increments. When the counter equals the toggle-rate value it reloads to 0 and the phase inverts, so the phase inverts once every rate+1 ticks.
- R7: A write to the toggle-rate register clears the tick counter and forces the phase to "on" in the same clock edge, taking priority over a coincident `tick`.
- R8: In static mode `segOn[7:2]` are forced to 0 while the data and mask registers keep their contents; returning to 4-mux restores those outputs.
- R9: `segOn` bit n is the segment on common n/2 of pin n%2, and mask bit n gates the same segment as data bit n.
- R10: The phase changes only on a `tick` or a toggle-rate write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse that advances the blink divider |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr` |
| segOn | output | 8 | Effective segment-on bits, bit n = common n/2, pin n%2 |

## Verification
Directed patterns come first. With the mask clear, a full data byte separates steady display from blinking. With the mask and data both full at a small rate, the exact tick on which the phase flips is pinned down, and idle cycles between ticks show the phase holds. A partial data byte under a full mask shows that blinking never lights a segment whose data bit is 0. A rate write issued in the off phase confirms the restart. Static mode is checked with all data set, to show the upper outputs are gated while their register contents survive. A long seeded random run then mixes writes to every address, unmapped reads and ticks. Its output is compared each cycle with a bench model, which catches wrong write-versus-tick priority and off-by-one counter reloads.

// File: rtl/lcd_blink_pkg.sv
package lcd_blink_pkg;

  // Write strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic wrMask;
    logic wrData;
    logic wrRate;
    logic wrMode;
  } regStrobe_t;

endpackage

// File: rtl/lcd_blink_ctrl.sv
module lcd_blink_ctrl
  import lcd_blink_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUS_W     = 8,
  parameter int SEG_N     = 8,
  parameter int RATE_W    = 8,
  parameter int BASE_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [SEG_N-1:0]  maskVal,
  input  logic [SEG_N-1:0]  dataVal,
  input  logic [RATE_W-1:0] rateVal,
  input  logic              modeVal,
  output regStrobe_t        strobe,
  output logic [BUS_W-1:0]  busRdData
);

  localparam logic [ADDR_W-1:0] ADR_MASK = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] ADR_DATA = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] ADR_RATE = ADDR_W'(BASE_ADDR + 2);
  localparam logic [ADDR_W-1:0] ADR_MODE = ADDR_W'(BASE_ADDR + 3);

  logic hitMask, hitData, hitRate, hitMode;

  assign hitMask = (busAddr == ADR_MASK);
  assign hitData = (busAddr == ADR_DATA);
  assign hitRate = (busAddr == ADR_RATE);
  assign hitMode = (busAddr == ADR_MODE);

  always_comb begin
    strobe.wrMask = busWrEn & hitMask;
    strobe.wrData = busWrEn & hitData;
    strobe.wrRate = busWrEn & hitRate;
    strobe.wrMode = busWrEn & hitMode;
  end

  always_comb begin
    busRdData = '0;
    if (hitMask)      busRdData[SEG_N-1:0]  = maskVal;
    else if (hitData) busRdData[SEG_N-1:0]  = dataVal;
    else if (hitRate) busRdData[RATE_W-1:0] = rateVal;
    else if (hitMode) busRdData[0]          = modeVal;
  end

  // R2: at most one register written per cycle
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMask, strobe.wrData, strobe.wrRate, strobe.wrMode}));

  // R2: addresses outside the map read as zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(hitMask | hitData | hitRate | hitMode) |-> (busRdData == '0));

endmodule

// File: rtl/lcd_blink_dp.sv
module lcd_blink_dp
  import lcd_blink_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int PIN_N  = 2,
  parameter int COM_N  = 4,
  parameter int RATE_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  regStrobe_t             strobe,
  input  logic [BUS_W-1:0]       wrData,
  output logic [PIN_N*COM_N-1:0] maskVal,
  output logic [PIN_N*COM_N-1:0] dataVal,
  output logic [RATE_W-1:0]      rateVal,
  output logic                   modeVal,
  output logic [PIN_N*COM_N-1:0] segOn
);

  localparam int SEG_N = PIN_N * COM_N;

  logic [SEG_N-1:0]  maskReg, dataReg, segEnable;
  logic [RATE_W-1:0] rateReg, tickCnt;
  logic              modeMux, phaseOn, cntHit;

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      dataReg <= '0;
      rateReg <= '0;
      modeMux <= 1'b0;
    end else begin
      if (strobe.wrMask) maskReg <= wrData[SEG_N-1:0];
      if (strobe.wrData) dataReg <= wrData[SEG_N-1:0];
      if (strobe.wrRate) rateReg <= wrData[RATE_W-1:0];
      if (strobe.wrMode) modeMux <= wrData[0];
    end
  end

  // Blink divider: a rate write restarts it, otherwise ticks advance it
  assign cntHit = (tickCnt == rateReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      phaseOn <= 1'b1;
    end else if (strobe.wrRate) begin
      tickCnt <= '0;
      phaseOn <= 1'b1;
    end else if (tick) begin
      if (cntHit) begin
        tickCnt <= '0;
        phaseOn <= ~phaseOn;
      end else begin
        tickCnt <= tickCnt + RATE_W'(1);
      end
    end
  end

  // Per-segment gating; static drive keeps only the common-0 segments
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    localparam bit IN_STATIC = (s < PIN_N);
    assign segEnable[s] = modeMux | IN_STATIC;
    assign segOn[s]     = dataReg[s] & ~(maskReg[s] & ~phaseOn) & segEnable[s];
  end

  assign maskVal = maskReg;
  assign dataVal = dataReg;
  assign rateVal = rateReg;
  assign modeVal = modeMux;

  // R6: the counter never passes the reload value
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= rateReg);

  // R7: a rate write restarts the divider in the on phase
  assert_rate_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrRate |=> (phaseOn && tickCnt == '0));

  // R10: without a tick or rate write the phase holds
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.wrRate) |=> $stable(phaseOn));

  // R8: static drive leaves the upper segments dark
  assert_static_dark_R8: assert property (@(posedge clk) disable iff (!rstN)
    !modeMux |-> (segOn[SEG_N-1:PIN_N] == '0));

  // R5: no segment is lit without its data bit
  assert_data_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (segOn & ~dataReg) == '0);

endmodule

// File: rtl/lcd_blink_top.sv
module lcd_blink_top
  import lcd_blink_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUS_W     = 8,
  parameter int PIN_N     = 2,
  parameter int COM_N     = 4,
  parameter int RATE_W    = 8,
  parameter int BASE_ADDR = 'h80
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic [BUS_W-1:0]       busWrData,
  output logic [BUS_W-1:0]       busRdData,
  output logic [PIN_N*COM_N-1:0] segOn
);

  localparam int SEG_N = PIN_N * COM_N;

  regStrobe_t        strobe;
  logic [SEG_N-1:0]  maskVal, dataVal;
  logic [RATE_W-1:0] rateVal;
  logic              modeVal;

  lcd_blink_ctrl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .SEG_N(SEG_N),
    .RATE_W(RATE_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .maskVal(maskVal), .dataVal(dataVal), .rateVal(rateVal),
    .modeVal(modeVal), .strobe(strobe), .busRdData(busRdData)
  );

  lcd_blink_dp #(
    .BUS_W(BUS_W), .PIN_N(PIN_N), .COM_N(COM_N), .RATE_W(RATE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strobe(strobe),
    .wrData(busWrData), .maskVal(maskVal), .dataVal(dataVal),
    .rateVal(rateVal), .modeVal(modeVal), .segOn(segOn)
  );

endmodule

// File: tb/lcd_blink_top_bench.sv
module lcd_blink_top_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] segOn;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // Bench model state
  logic [7:0] mMask = 0, mData = 0, mRate = 0, mCnt = 0;
  logic       mMode = 0, mPhaseOn = 1;

  lcd_blink_top u_lcd_blink_top (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .segOn(segOn)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] expSeg();
    logic [7:0] gateOff = mPhaseOn ? 8'h00 : 8'hFF;
    logic [7:0] live    = mMode ? 8'hFF : 8'h03;
    return mData & ~(mMask & gateOff) & live;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h80:   return mMask;
      8'h81:   return mData;
      8'h82:   return mRate;
      8'h83:   return {7'b0, mMode};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle and updates the model at the edge.
  task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d, input logic tk);
    busWrEn = wr; busAddr = a; busWrData = d; tick = tk;
    @(posedge clk);
    if (wr && a == 8'h82) begin
      mRate = d; mCnt = 0; mPhaseOn = 1;
    end else begin
      if (wr && a == 8'h80) mMask = d;
      if (wr && a == 8'h81) mData = d;
      if (wr && a == 8'h83) mMode = d[0];
      if (tk) begin
        if (mCnt == mRate) begin mCnt = 0; mPhaseOn = ~mPhaseOn; end
        else mCnt = mCnt + 8'd1;
      end
    end
    @(negedge clk);
    busWrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic readChk(input string req, input logic [7:0] a, input logic [7:0] exp);
    busAddr = a; #1;
    check(req, busRdData, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 segOn", segOn, 8'h00);
    readChk("R1 mask", 8'h80, 8'h00);
    readChk("R1 data", 8'h81, 8'h00);
    readChk("R1 rate", 8'h82, 8'h00);
    readChk("R1 mode", 8'h83, 8'h00);

    // R2: readback and unmapped reads
    wr(8'h80, 8'hA5);
    readChk("R2 mask", 8'h80, 8'hA5);
    wr(8'h83, 8'hFF);
    readChk("R2 mode bit0 only", 8'h83, 8'h01);
    readChk("R2 unmapped 84", 8'h84, 8'h00);
    readChk("R2 unmapped 7F", 8'h7F, 8'h00);
    readChk("R2 unmapped 00", 8'h00, 8'h00);

    // R3, R9: mask clear, 4-mux, single segment positions
    wr(8'h80, 8'h00);
    wr(8'h81, 8'hFF);
    check("R3 steady full", segOn, 8'hFF);
    wr(8'h81, 8'h20);
    check("R9 bit5 = com2 pin1", segOn, 8'h20);

    // R6, R4, R10: rate 3 -> phase flips on 4th tick
    wr(8'h81, 8'hFF);
    wr(8'h80, 8'hFF);
    wr(8'h82, 8'h03);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 8'h00, 8'h00, 1'b1);
      check("R6 before reload", segOn, 8'hFF);
    end
    step(1'b0, 8'h00, 8'h00, 1'b1);
    check("R4 off phase", segOn, 8'h00);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 8'h00, 8'h00, 1'b0);
      check("R10 hold without tick", segOn, 8'h00);
    end

    // R5: data 0 under full mask stays dark in both phases
    wr(8'h81, 8'h0F);
    check("R5 off phase", segOn, 8'h00);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00, 1'b1);
    check("R5 on phase", segOn, 8'h0F);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00, 1'b1);
    check("R4 back off", segOn, 8'h00);

    // R7: rate write with coincident tick restarts in on phase
    step(1'b1, 8'h82, 8'h03, 1'b1);
    check("R7 restart on", segOn, 8'h0F);
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 8'h00, 1'b1);
    check("R7 counter cleared", segOn, 8'h0F);

    // R8: static mode gating, contents kept
    wr(8'h80, 8'h00);
    wr(8'h81, 8'hFF);
    wr(8'h83, 8'h00);
    check("R8 static outputs", segOn, 8'h03);
    readChk("R8 data kept", 8'h81, 8'hFF);
    wr(8'h83, 8'h01);
    check("R8 restore 4-mux", segOn, 8'hFF);

    // Random mix against the model
    begin
      int seed = 1234;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        logic [7:0] a = 8'h80 + 8'($urandom_range(0, 4));
        logic [7:0] d = 8'($urandom);
        logic       w = ($urandom_range(0, 3) == 0);
        logic       t = ($urandom_range(0, 1) == 0);
        if (a == 8'h82) d = 8'($urandom_range(0, 5));
        step(w, a, d, t);
        check("R4 R6 random segOn", segOn, expSeg());
        if (i % 8 == 0) begin
          logic [7:0] ra = ($urandom_range(0, 5) == 0) ? 8'($urandom) : a;
          readChk("R2 random read", ra, expRead(ra));
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule